// File: doc/BRIEF.md
# Programmable Divider Pair with Three-State Phase Detector

This block is the digital half of a frequency synthesiser loop. One counter divides an oscillator clock by a feedback ratio. A second counter divides a reference clock by a reference ratio. A three-state detector watches the rising edges of the two divided clocks. It raises a pump-up or pump-down output for the time by which one edge leads the other. When neither edge is waiting, both outputs rest low, and the analog pump reads this as its high-impedance state.

Both ratios come in on parallel ports. A load strobe stages them, and each counter starts using its new ratio only when its current divided period ends. A sense input swaps the two pump outputs, so the block can drive either polarity of external filter. Both divided clocks are brought out so the loop can be observed. The charge pump, the filter and the oscillator lie outside the block.

Top module: `pll_divider_pfd`

## Requirements
- R1: The feedback ratio accepts every integer from 2 to 16383. The divided feedback clock rises at the first oscillator rising edge of each period and then once every N oscillator edges. It is high for ceil(N/2) of those edges and low for floor(N/2). A loaded value of 0 or 1 is used as 2.
- R2: The reference ratio accepts every integer from 1 to 1023. For ratios of 2 or more it follows the same period and duty rule as R1, counted on reference clock edges. A loaded value of 0 is used as 1.
- R3: While the reference ratio in use is 1, the divided reference output equals the reference clock itself.
- R4: With the sense input at 0, if a divided-reference rising edge arrives while no feedback edge is pending, pump_up goes high at that edge and stays high until the next divided-feedback rising edge.
- R5: With the sense input at 0, if a divided-feedback rising edge arrives while no reference edge is pending, pump_dn goes high at that edge and stays high until the next divided-reference rising edge.
- R6: When no edge is pending, both pump outputs are low. The two pump outputs are never high together.
- R7: Each correction pulse lasts exactly the time between the leading edge and the lagging edge. When both edges have arrived, both detector state bits clear at once.
- R8: With the sense input at 1, the meanings of pump_up and pump_dn are exchanged.
- R9: Each counter samples the ratio ports on every edge of its own clock while ratio_load is high. The staged value takes effect only at the start of the next divided period, so the current period always finishes with the old ratio. Ratio changes made while ratio_load is low have no effect.
- R10: rst_n is active low and is sampled on each clock edge. During reset both pumps are low, fb_div is low, and ref_div is low unless the reference ratio is 1. Each divided clock rises at the first edge of its own clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator clock to be divided by the feedback ratio |
| rst_n | input | 1 | Active-low reset, sampled in each clock domain |
| fb_ratio | input | 14 | Feedback divide ratio |
| ref_ratio | input | 10 | Reference divide ratio |
| pump_swap | input | 1 | 1 exchanges the pump-up and pump-down outputs |
| ratio_load | input | 1 | Stages the ratio ports into both counters |
| pump_up | output | 1 | Correction pulse that raises the oscillator frequency |
| pump_dn | output | 1 | Correction pulse that lowers the oscillator frequency |
| ref_div | output | 1 | Divided reference clock |
| fb_div | output | 1 | Divided feedback clock |

## Verification
The oscillator runs open loop at a period that no edge of the reference ever lands on. Each ratio pair is chosen so that its divided edges drift steadily against each other. One pair makes the feedback side faster, so the pump-down pulses widen. Another makes the reference side faster, so pump_up is used, and frequency-mismatch runs check that a repeated edge on the leading side leaves the pulse unchanged. Further runs cover the reference bypass, ratios below the legal minimum, the largest ratios, ratio edits made without the strobe, and a sense swap. These runs separate a polarity fault, a duty or period fault, and a ratio taken mid-period from the correct behaviour.

// File: rtl/pll_core_pkg.sv
`timescale 1ns/10ps
// Shared definitions for the divider and detector core.
// Assumes: ratios are unsigned binary; widths fixed by the top's parameters.
package pll_core_pkg;

    // Smallest usable ratio of each counter.
    localparam int FB_MIN_RATIO  = 2;
    localparam int REF_MIN_RATIO = 1;

    // Meaning of the sense input.
    typedef enum logic {
        PUMP_DIRECT  = 1'b0,
        PUMP_SWAPPED = 1'b1
    } pump_sense_e;

endpackage

// File: rtl/pll_ratio_counter.sv
`timescale 1ns/10ps
// Programmable down-counter producing a divided clock.
// Counts ratio-1 down to 0. The output is high for ceil(ratio/2) input edges
// starting at the reload edge. A ratio staged by load_i is adopted only at
// the terminal count. With ALLOW_BYPASS set, a ratio of 1 routes the input
// clock straight to the output. Assumes rst_ni is synchronous to clk_i.
module pll_ratio_counter #(
    parameter int WIDTH        = 10,
    parameter int MIN_RATIO    = 1,
    parameter bit ALLOW_BYPASS = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] ratio_i,
    input  logic             load_i,
    output logic             div_o
);

    localparam logic [WIDTH-1:0] FLOOR = WIDTH'(MIN_RATIO);

    logic [WIDTH-1:0] legal_ratio;
    logic [WIDTH-1:0] staged_q;
    logic [WIDTH-1:0] active_q;
    logic [WIDTH-1:0] count_q;
    logic             level_q;
    logic             wrap;
    logic [WIDTH-1:0] active_nxt;
    logic [WIDTH-1:0] count_nxt;
    logic             level_nxt;

    // Raise an out-of-range request to the smallest usable ratio.
    always_comb begin
        legal_ratio = (ratio_i < FLOOR) ? FLOOR : ratio_i;
    end

    // Next-state: reload at terminal count, otherwise count down.
    always_comb begin
        wrap       = (count_q == '0);
        active_nxt = wrap ? (load_i ? legal_ratio : staged_q) : active_q;
        count_nxt  = wrap ? (active_nxt - 1'b1) : (count_q - 1'b1);
        level_nxt  = (count_nxt >= (active_nxt >> 1));
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            staged_q <= legal_ratio;
            active_q <= legal_ratio;
            count_q  <= '0;
            level_q  <= 1'b0;
        end else begin
            if (load_i) begin
                staged_q <= legal_ratio;
            end
            active_q <= active_nxt;
            count_q  <= count_nxt;
            level_q  <= level_nxt;
        end
    end

    // Output selection: optional pass-through for a ratio of one.
    generate
        if (ALLOW_BYPASS) begin : g_bypass
            logic pass_through;
            assign pass_through = (active_q == WIDTH'(1));
            assign div_o        = pass_through ? clk_i : level_q;
        end else begin : g_plain
            assign div_o = level_q;
        end
    endgenerate

    AST_COUNT_BELOW_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q < active_q);                                                  // R1
    AST_RATIO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_q >= FLOOR);                                                   // R2
    AST_RATIO_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_q != $past(active_q)) |-> ($past(count_q) == '0));            // R9

endmodule

// File: rtl/pll_pfd_tristate.sv
`timescale 1ns/10ps
// Three-state phase-frequency detector.
// One flag is set by each divided-clock rising edge. When both flags are set,
// a shared asynchronous clear drops them together, so the leading flag stays
// high exactly from its edge to the lagging edge. Reset joins the clear path.
// The sense input exchanges the two outputs. Assumes glitch-free edge inputs.
module pll_pfd_tristate
    import pll_core_pkg::*;
(
    input  logic        ref_edge_i,
    input  logic        fb_edge_i,
    input  logic        rst_ni,
    input  pump_sense_e sense_i,
    output logic        up_o,
    output logic        dn_o
);

    logic ref_lead_q;
    logic fb_lead_q;
    logic clear;

    // Shared clear: both edges seen, or reset held.
    assign clear = (ref_lead_q & fb_lead_q) | ~rst_ni;

    // Reference-side flag.
    always_ff @(posedge ref_edge_i or posedge clear) begin
        if (clear) ref_lead_q <= 1'b0;
        else       ref_lead_q <= 1'b1;
    end

    // Feedback-side flag.
    always_ff @(posedge fb_edge_i or posedge clear) begin
        if (clear) fb_lead_q <= 1'b0;
        else       fb_lead_q <= 1'b1;
    end

    // Output sense selection.
    always_comb begin
        if (sense_i == PUMP_SWAPPED) begin
            up_o = fb_lead_q;
            dn_o = ref_lead_q;
        end else begin
            up_o = ref_lead_q;
            dn_o = fb_lead_q;
        end
    end

    AST_NO_DUAL_LEAD: assert property (@(posedge ref_edge_i) disable iff (!rst_ni)
        !(ref_lead_q && fb_lead_q));                                          // R7

endmodule

// File: rtl/pll_divider_pfd.sv
`timescale 1ns/10ps
// Top of the synthesiser loop digital core: reference and feedback ratio
// counters feeding a three-state phase detector.
// Assumes rst_n meets setup to both clocks, and that ratio_load and the
// ratio ports are held steady across at least one edge of each clock.
module pll_divider_pfd #(
    parameter int N_WIDTH = 14,
    parameter int R_WIDTH = 10
) (
    input  logic               ref_clk,
    input  logic               vco_clk,
    input  logic               rst_n,
    input  logic [N_WIDTH-1:0] fb_ratio,
    input  logic [R_WIDTH-1:0] ref_ratio,
    input  logic               pump_swap,
    input  logic               ratio_load,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               ref_div,
    output logic               fb_div
);
    import pll_core_pkg::*;

    pump_sense_e sense;
    assign sense = pump_sense_e'(pump_swap);

    pll_ratio_counter #(
        .WIDTH       (R_WIDTH),
        .MIN_RATIO   (REF_MIN_RATIO),
        .ALLOW_BYPASS(1'b1)
    ) u_ref_counter (
        .clk_i  (ref_clk),
        .rst_ni (rst_n),
        .ratio_i(ref_ratio),
        .load_i (ratio_load),
        .div_o  (ref_div)
    );

    pll_ratio_counter #(
        .WIDTH       (N_WIDTH),
        .MIN_RATIO   (FB_MIN_RATIO),
        .ALLOW_BYPASS(1'b0)
    ) u_fb_counter (
        .clk_i  (vco_clk),
        .rst_ni (rst_n),
        .ratio_i(fb_ratio),
        .load_i (ratio_load),
        .div_o  (fb_div)
    );

    pll_pfd_tristate u_detector (
        .ref_edge_i(ref_div),
        .fb_edge_i (fb_div),
        .rst_ni    (rst_n),
        .sense_i   (sense),
        .up_o      (pump_up),
        .dn_o      (pump_dn)
    );

    AST_PUMP_EXCLUSIVE: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !(pump_up && pump_dn));                                               // R6
    AST_PUMP_EXCLUSIVE_REF: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(pump_up && pump_dn));                                               // R6

endmodule

// File: tb/pll_divider_pfd_bench.sv
`timescale 1ns/10ps
module pll_divider_pfd_bench;

    logic        ref_clk = 1'b0;
    logic        vco_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] fb_ratio = 14'd6;
    logic [9:0]  ref_ratio = 10'd4;
    logic        pump_swap = 1'b0;
    logic        ratio_load = 1'b0;
    logic        pump_up, pump_dn, ref_div, fb_div;
    logic        any_pump;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural reference model state.
    int      fb_act, fb_pend, fb_phase, fb_left;
    int      rf_act, rf_pend, rf_phase, rf_left;
    bit      m_ref_lead = 0, m_fb_lead = 0;
    realtime m_start = 0.0, m_width = 0.0, t_dut_start = 0.0;
    bit      width_due = 0;

    always #2.5 ref_clk = ~ref_clk;   // 200 MHz reference
    always #1.6 vco_clk = ~vco_clk;   // behavioural oscillator

    pll_divider_pfd u_pll_divider_pfd (
        .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
        .fb_ratio(fb_ratio), .ref_ratio(ref_ratio), .pump_swap(pump_swap),
        .ratio_load(ratio_load), .pump_up(pump_up), .pump_dn(pump_dn),
        .ref_div(ref_div), .fb_div(fb_div)
    );

    assign any_pump = pump_up | pump_dn;
    always @(posedge any_pump) t_dut_start = $realtime;

    function automatic int legal_fb(int v);
        return (v < 2) ? 2 : v;
    endfunction
    function automatic int legal_rf(int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $realtime);
        end
    endtask

    // Detector model: a divided edge either starts a pulse or ends the other side's.
    task automatic pfd_edge(bit from_fb);
        if (from_fb) begin
            if (m_ref_lead) begin
                m_ref_lead = 0; m_width = $realtime - m_start; width_due = 1;
            end else if (!m_fb_lead) begin
                m_fb_lead = 1; m_start = $realtime;
            end
        end else begin
            if (m_fb_lead) begin
                m_fb_lead = 0; m_width = $realtime - m_start; width_due = 1;
            end else if (!m_ref_lead) begin
                m_ref_lead = 1; m_start = $realtime;
            end
        end
    endtask

    task automatic check_pumps();
        realtime meas;
        check_bit("R4 R8", "pump_up", pump_up, pump_swap ? m_fb_lead : m_ref_lead);
        check_bit("R5 R8", "pump_dn", pump_dn, pump_swap ? m_ref_lead : m_fb_lead);
        check_bit("R6", "pumps both high", pump_up & pump_dn, 1'b0);
        if (width_due) begin
            width_due = 0;
            meas = ($realtime - 0.05) - t_dut_start;
            n_chk++;
            if (meas - m_width > 0.02 || m_width - meas > 0.02) begin
                n_fail++;
                $display("FAIL R7 pulse width actual=%0.2f expected=%0.2f", meas, m_width);
            end
        end
    endtask

    // Feedback domain model step, compared shortly after each oscillator edge.
    always @(posedge vco_clk) begin
        bit edge_now;
        logic exp_lvl;
        edge_now = 0;
        if (!rst_n) begin
            fb_act = legal_fb(fb_ratio); fb_pend = fb_act; fb_left = 0; fb_phase = 0;
            exp_lvl = 1'b0;   // R10
        end else begin
            if (fb_left == 0) begin
                fb_act = ratio_load ? legal_fb(fb_ratio) : fb_pend;
                fb_phase = 0; fb_left = fb_act - 1; edge_now = 1;
            end else begin
                fb_phase++; fb_left--;
            end
            if (ratio_load) fb_pend = legal_fb(fb_ratio);
            exp_lvl = (fb_phase < (fb_act + 1) / 2);
            if (edge_now) pfd_edge(1);
        end
        #0.05;
        check_bit("R1 R9 R10", "fb_div", fb_div, exp_lvl);
        if (rst_n) check_pumps();
    end

    // Reference domain model step.
    always @(posedge ref_clk) begin
        bit edge_now;
        logic exp_lvl;
        edge_now = 0;
        if (!rst_n) begin
            rf_act = legal_rf(int'(ref_ratio)); rf_pend = rf_act; rf_left = 0; rf_phase = 0;
            exp_lvl = (rf_act == 1);   // R3 pass-through even in reset
        end else begin
            if (rf_left == 0) begin
                rf_act = ratio_load ? legal_rf(int'(ref_ratio)) : rf_pend;
                rf_phase = 0; rf_left = rf_act - 1; edge_now = 1;
            end else begin
                rf_phase++; rf_left--;
            end
            if (ratio_load) rf_pend = legal_rf(int'(ref_ratio));
            exp_lvl = (rf_phase < (rf_act + 1) / 2);
            if (edge_now) pfd_edge(0);
        end
        #0.05;
        check_bit((rf_act == 1) ? "R3" : "R2 R9", "ref_div", ref_div, exp_lvl);
        if (rst_n) check_pumps();
    end

    task automatic load_ratios(int n, int r);
        fb_ratio = 14'(n); ref_ratio = 10'(r);
        ratio_load = 1'b1;
        #20;
        ratio_load = 1'b0;
    endtask

    initial begin
        #20.03;
        check_bit("R10", "pump_up in reset", pump_up, 1'b0);
        check_bit("R10", "pump_dn in reset", pump_dn, 1'b0);
        check_bit("R10", "fb_div in reset", fb_div, 1'b0);
        check_bit("R10", "ref_div in reset", ref_div, 1'b0);
        rst_n = 1'b1;
        #400;                       // feedback faster: pump_dn pulses widen
        fb_ratio = 14'd5;           // no strobe: must be ignored (R9)
        #200;
        load_ratios(3, 2);          // 9.6 ns vs 10 ns
        #300;
        load_ratios(2, 1);          // bypass, reference faster: pump_up (R3, R4)
        #300;
        pump_swap = 1'b1;           // R8
        #300;
        load_ratios(1, 0);          // clamped to 2 and 1 (R1, R2)
        #300;
        pump_swap = 1'b0;
        load_ratios(7, 5);
        #400;
        load_ratios(16383, 1023);   // largest ratios
        #110000;
        load_ratios(2, 1023);       // large mismatch, fb leads repeatedly
        #12000;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule